// File: doc/BRIEF.md
# Terminal Mode Tracker and Service Request Gate

This block keeps the operating mode of a voice network terminal and decides which user service requests may go to the network. A terminal is unsubscribed (idle), subscribed (active), or taking part in a conference (communicating). User requests come in as a valid strobe with a type code and an argument, such as a peer selection. A request that is legal in the present mode is passed on the outgoing request channel. Any other request is discarded and counted.

The mode never changes when a request is sent. It changes only when the network answers with a confirmation, or when a conference-ended event arrives. Only one request can be outstanding at a time. A strap input is sampled on the first clock after reset. It selects the base-station role, and in that role user requests are never forwarded. The mode, the outstanding flag and the drop count form the status used for display.

Top module: `term_mode_ctrl`

## Requirements
- R1: After reset the mode reads idle (code 0), pending_o and fwd_valid_o are low, and drop_cnt_o is zero.
- R2: role_strap_i is sampled on the first clock edge after reset release. If it is high the mode becomes base (code 3) and stays there until the next reset, and every request is dropped. Any request presented in that first cycle is dropped whatever the strap value.
- R3: In idle, only subscribe (type 0) is forwarded. Every other type is dropped.
- R4: A confirmed subscribe moves idle to active (code 1). A confirmed unsubscribe (type 1) moves active to idle. Idle never goes straight to communicating.
- R5: Start-conference (type 3) is forwarded only in active. When confirmed, the mode becomes communicating (code 2).
- R6: End-conference (type 5) is forwarded only in communicating, and its confirmation returns the mode to active. A high end_conf_i while communicating also returns the mode to active at the next edge, even if a confirmation arrives in the same cycle.
- R7: Subscribe in active or communicating is dropped. Unsubscribe in communicating is dropped. Type codes 6 and 7 are dropped in every mode.
- R8: Query (type 2) and broadcast (type 4) are forwarded in active and communicating. Their confirmation leaves the mode unchanged.
- R9: An accepted request appears on fwd_valid_o for exactly one cycle, at the edge after it is presented, with its type and argument. pending_o rises at the same edge and stays high until a confirm or reject arrives.
- R10: While pending_o is high, every request is dropped. This includes a request presented in the same cycle as the answer.
- R11: A reject (cnf_valid_i with cnf_ok_i low) clears pending_o and leaves the mode unchanged. cnf_valid_i with nothing pending has no effect.
- R12: drop_cnt_o increases by one for each dropped request and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_strap_i | input | 1 | Role select, high for base station, sampled after reset |
| req_valid_i | input | 1 | User request strobe |
| req_type_i | input | 3 | Request type code |
| req_arg_i | input | ARG_W | Request argument (peer selection) |
| cnf_valid_i | input | 1 | Network answer strobe |
| cnf_ok_i | input | 1 | High to confirm, low to reject |
| end_conf_i | input | 1 | Conference-ended event from the network |
| fwd_valid_o | output | 1 | Forwarded request strobe |
| fwd_type_o | output | 3 | Forwarded request type |
| fwd_arg_o | output | ARG_W | Forwarded request argument |
| mode_o | output | 2 | Mode: 0 idle, 1 active, 2 communicating, 3 base |
| pending_o | output | 1 | A request is awaiting an answer |
| drop_cnt_o | output | CNT_W | Saturating count of dropped requests |

## Verification
Two events can land on the same edge. The first is a new user request arriving together with the network answer that closes the outstanding one. The second is a conference-ended event arriving together with a confirmation that would otherwise set the mode. Both are driven on purpose in directed steps and then occur again many times in a long random phase. A behavioural model that holds the outstanding request decides each outcome and is compared with every output on every cycle. The request must be counted as dropped, and the end event must leave the terminal in active.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int TYPE_W = 3;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ACTIVE = 2'd1,
    MODE_COMM   = 2'd2,
    MODE_BASE   = 2'd3
  } mode_e;

  typedef enum logic [TYPE_W-1:0] {
    RQ_SUB    = 3'd0,
    RQ_UNSUB  = 3'd1,
    RQ_QUERY  = 3'd2,
    RQ_CONF   = 3'd3,
    RQ_BCAST  = 3'd4,
    RQ_ENDCNF = 3'd5,
    RQ_RSV6   = 3'd6,
    RQ_RSV7   = 3'd7
  } req_e;
endpackage

// File: rtl/tmc_req_filter.sv
module tmc_req_filter
  import tmc_pkg::*;
(
  input  mode_e             mode_i,
  input  logic              settled_i,
  input  logic              pending_i,
  input  logic              req_valid_i,
  input  logic [TYPE_W-1:0] req_type_i,
  output logic              accept_o,
  output logic              drop_o
);
  logic legal;

  always_comb begin
    legal = 1'b0;
    unique case (mode_i)
      MODE_IDLE:   legal = (req_type_i == RQ_SUB);
      MODE_ACTIVE: legal = (req_type_i == RQ_UNSUB) || (req_type_i == RQ_QUERY) ||
                           (req_type_i == RQ_CONF)  || (req_type_i == RQ_BCAST);
      MODE_COMM:   legal = (req_type_i == RQ_QUERY) || (req_type_i == RQ_BCAST) ||
                           (req_type_i == RQ_ENDCNF);
      MODE_BASE:   legal = 1'b0;
      default:     legal = 1'b0;
    endcase
  end

  always_comb begin
    accept_o = req_valid_i && settled_i && !pending_i && legal;
    drop_o   = req_valid_i && !accept_o;
  end
endmodule

// File: rtl/tmc_drop_ctr.sv
module tmc_drop_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmc_mode_fsm.sv
module tmc_mode_fsm
  import tmc_pkg::*;
#(
  parameter int ARG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              accept_i,
  input  logic [TYPE_W-1:0] req_type_i,
  input  logic [ARG_W-1:0]  req_arg_i,
  input  logic              cnf_valid_i,
  input  logic              cnf_ok_i,
  input  logic              end_conf_i,
  output mode_e             mode_o,
  output logic              settled_o,
  output logic              pending_o,
  output logic              fwd_valid_o,
  output logic [TYPE_W-1:0] fwd_type_o,
  output logic [ARG_W-1:0]  fwd_arg_o
);
  mode_e             mode_q, mode_d;
  logic              first_q;
  logic              pend_q, pend_d;
  logic [TYPE_W-1:0] ptype_q;
  logic              fwd_q;
  logic [TYPE_W-1:0] ftype_q;
  logic [ARG_W-1:0]  farg_q;
  logic              answer;

  assign answer = cnf_valid_i && pend_q;

  // next mode
  always_comb begin
    mode_d = mode_q;
    if (first_q) begin
      mode_d = strap_i ? MODE_BASE : MODE_IDLE;
    end else begin
      if (answer && cnf_ok_i) begin
        unique case (ptype_q)
          RQ_SUB:    if (mode_q == MODE_IDLE)   mode_d = MODE_ACTIVE;
          RQ_UNSUB:  if (mode_q == MODE_ACTIVE) mode_d = MODE_IDLE;
          RQ_CONF:   if (mode_q == MODE_ACTIVE) mode_d = MODE_COMM;
          RQ_ENDCNF: if (mode_q == MODE_COMM)   mode_d = MODE_ACTIVE;
          default:   mode_d = mode_q;
        endcase
      end
      if (end_conf_i && (mode_q == MODE_COMM)) mode_d = MODE_ACTIVE;
    end
  end

  // outstanding slot
  always_comb begin
    pend_d = pend_q;
    if (accept_i)    pend_d = 1'b1;
    else if (answer) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      first_q <= 1'b1;
      pend_q  <= 1'b0;
      fwd_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      first_q <= 1'b0;
      pend_q  <= pend_d;
      fwd_q   <= accept_i;
    end
  end

  // request holding registers, loaded on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptype_q <= '0;
      ftype_q <= '0;
      farg_q  <= '0;
    end else if (accept_i) begin
      ptype_q <= req_type_i;
      ftype_q <= req_type_i;
      farg_q  <= req_arg_i;
    end
  end

  assign mode_o      = mode_q;
  assign settled_o   = !first_q;
  assign pending_o   = pend_q;
  assign fwd_valid_o = fwd_q;
  assign fwd_type_o  = ftype_q;
  assign fwd_arg_o   = farg_q;
endmodule

// File: rtl/term_mode_ctrl.sv
module term_mode_ctrl
  import tmc_pkg::*;
#(
  parameter int ARG_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_strap_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_type_i,
  input  logic [ARG_W-1:0]  req_arg_i,
  input  logic              cnf_valid_i,
  input  logic              cnf_ok_i,
  input  logic              end_conf_i,
  output logic              fwd_valid_o,
  output logic [2:0]        fwd_type_o,
  output logic [ARG_W-1:0]  fwd_arg_o,
  output logic [1:0]        mode_o,
  output logic              pending_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  mode_e mode;
  logic  settled, pending, accept, drop;

  tmc_req_filter u_filter (
    .mode_i      (mode),
    .settled_i   (settled),
    .pending_i   (pending),
    .req_valid_i (req_valid_i),
    .req_type_i  (req_type_i),
    .accept_o    (accept),
    .drop_o      (drop)
  );

  tmc_mode_fsm #(.ARG_W(ARG_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (role_strap_i),
    .accept_i    (accept),
    .req_type_i  (req_type_i),
    .req_arg_i   (req_arg_i),
    .cnf_valid_i (cnf_valid_i),
    .cnf_ok_i    (cnf_ok_i),
    .end_conf_i  (end_conf_i),
    .mode_o      (mode),
    .settled_o   (settled),
    .pending_o   (pending),
    .fwd_valid_o (fwd_valid_o),
    .fwd_type_o  (fwd_type_o),
    .fwd_arg_o   (fwd_arg_o)
  );

  tmc_drop_ctr #(.CNT_W(CNT_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (drop),
    .cnt_o (drop_cnt_o)
  );

  assign mode_o    = mode;
  assign pending_o = pending;
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker #(
  parameter int ARG_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             cnf_valid_i,
  input logic             cnf_ok_i,
  input logic             end_conf_i,
  input logic             fwd_valid_o,
  input logic [2:0]       fwd_type_o,
  input logic [1:0]       mode_o,
  input logic             pending_o,
  input logic [CNT_W-1:0] drop_cnt_o
);
  AST_FWD_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> pending_o); // R9

  AST_NO_FWD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && $past(pending_o)) |-> !fwd_valid_o); // R10

  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnf_valid_i && !cnf_ok_i && pending_o && !end_conf_i && !req_valid_i)
      |=> (mode_o == $past(mode_o)) && !pending_o); // R11

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o |=> (drop_cnt_o == $past(drop_cnt_o)) ||
                  (drop_cnt_o == $past(drop_cnt_o) + 1'b1)); // R12

  AST_CONF_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_o && fwd_type_o == 3'd3) |-> $past(mode_o) == 2'd1); // R5

  AST_IDLE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |=> mode_o != 2'd2); // R4

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |=> (mode_o == 2'd3) && !fwd_valid_o); // R2
endmodule

bind term_mode_ctrl tmc_checker #(.ARG_W(ARG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .cnf_valid_i (cnf_valid_i),
  .cnf_ok_i    (cnf_ok_i),
  .end_conf_i  (end_conf_i),
  .fwd_valid_o (fwd_valid_o),
  .fwd_type_o  (fwd_type_o),
  .mode_o      (mode_o),
  .pending_o   (pending_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/term_mode_ctrl_tb.sv
`timescale 1ns/1ps
module term_mode_ctrl_tb;
  localparam int ARG_W = 8;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic role_strap_i, req_valid_i, cnf_valid_i, cnf_ok_i, end_conf_i;
  logic [2:0] req_type_i;
  logic [ARG_W-1:0] req_arg_i;
  logic fwd_valid_o, pending_o;
  logic [2:0] fwd_type_o;
  logic [ARG_W-1:0] fwd_arg_o;
  logic [1:0] mode_o;
  logic [CNT_W-1:0] drop_cnt_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  term_mode_ctrl #(.ARG_W(ARG_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .role_strap_i(role_strap_i),
    .req_valid_i(req_valid_i), .req_type_i(req_type_i), .req_arg_i(req_arg_i),
    .cnf_valid_i(cnf_valid_i), .cnf_ok_i(cnf_ok_i), .end_conf_i(end_conf_i),
    .fwd_valid_o(fwd_valid_o), .fwd_type_o(fwd_type_o), .fwd_arg_o(fwd_arg_o),
    .mode_o(mode_o), .pending_o(pending_o), .drop_cnt_o(drop_cnt_o)
  );

  // behavioural reference: modes 0 idle 1 active 2 comm 3 base
  int m_mode, m_pend, m_ptype, m_fwd, m_ftype, m_farg, m_drop, m_first;

  function automatic bit legal(int md, int ty);
    if (md == 0) return ty == 0;
    if (md == 1) return ty == 1 || ty == 2 || ty == 3 || ty == 4;
    if (md == 2) return ty == 2 || ty == 4 || ty == 5;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_ptype = 0; m_fwd = 0;
      m_ftype = 0; m_farg = 0; m_drop = 0; m_first = 1;
    end else begin
      int nmode;
      bit acc;
      acc = req_valid_i && !m_first && !m_pend && legal(m_mode, int'(req_type_i));
      if (req_valid_i && !acc && m_drop < CMAX) m_drop++;
      nmode = m_mode;
      if (m_first) nmode = role_strap_i ? 3 : 0;
      else begin
        if (cnf_valid_i && m_pend && cnf_ok_i) begin
          if (m_ptype == 0 && m_mode == 0) nmode = 1;
          if (m_ptype == 1 && m_mode == 1) nmode = 0;
          if (m_ptype == 3 && m_mode == 1) nmode = 2;
          if (m_ptype == 5 && m_mode == 2) nmode = 1;
        end
        if (end_conf_i && m_mode == 2) nmode = 1;
      end
      if (acc) begin
        m_pend = 1; m_ptype = req_type_i; m_ftype = req_type_i; m_farg = req_arg_i;
      end else if (cnf_valid_i && m_pend) m_pend = 0;
      m_fwd = acc;
      m_mode = nmode;
      m_first = 0;
    end
  end

  // cycle compare against model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(mode_o) != m_mode) begin
        errors++; $display("FAIL R3 R4 R5 R6 mode act=%0d exp=%0d t=%0t", mode_o, m_mode, $time);
      end
      if (int'(pending_o) != m_pend || int'(fwd_valid_o) != m_fwd) begin
        errors++; $display("FAIL R9 R10 pend/fwd act=%0d/%0d exp=%0d/%0d t=%0t",
                           pending_o, fwd_valid_o, m_pend, m_fwd, $time);
      end
      if (m_fwd && (int'(fwd_type_o) != m_ftype || int'(fwd_arg_o) != m_farg)) begin
        errors++; $display("FAIL R9 fwd data act=%0d/%0d exp=%0d/%0d", fwd_type_o, fwd_arg_o, m_ftype, m_farg);
      end
      if (int'(drop_cnt_o) != m_drop) begin
        errors++; $display("FAIL R7 R12 drop act=%0d exp=%0d t=%0t", drop_cnt_o, m_drop, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    req_valid_i = 0; cnf_valid_i = 0; cnf_ok_i = 0; end_conf_i = 0;
  endtask

  task automatic req(input int ty, input int arg);
    @(negedge clk); idle_in();
    req_valid_i = 1; req_type_i = ty[2:0]; req_arg_i = arg[ARG_W-1:0];
    @(negedge clk); idle_in();
  endtask

  task automatic ans(input bit ok);
    @(negedge clk); idle_in();
    cnf_valid_i = 1; cnf_ok_i = ok;
    @(negedge clk); idle_in();
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk); idle_in(); role_strap_i = strap; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++; $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    rst_n = 0; role_strap_i = 0; req_type_i = 0; req_arg_i = 0; idle_in();
    #1;
    chk("R1 mode at reset", mode_o, 0);
    chk("R1 pending at reset", pending_o, 0);
    chk("R1 fwd at reset", fwd_valid_o, 0);
    chk("R1 drop at reset", drop_cnt_o, 0);
    do_reset(0);

    // R3: idle allows only subscribe
    req(2, 1);  chk("R3 query in idle dropped", drop_cnt_o, 1);
    req(3, 1);  chk("R3 conf in idle not pending", pending_o, 0);
    req(0, 9);  chk("R9 sub forwarded pending", pending_o, 1);
    req(1, 0);  chk("R10 request while pending dropped", drop_cnt_o, 3);
    ans(1);     chk("R4 sub confirmed -> active", mode_o, 1);
    req(0, 0);  chk("R7 sub in active dropped", drop_cnt_o, 4);
    req(2, 5);  ans(1); chk("R8 query confirmed keeps active", mode_o, 1);
    req(3, 7);  ans(0);
    chk("R11 reject keeps mode", mode_o, 1);
    chk("R11 reject clears pending", pending_o, 0);
    ans(1);     chk("R11 stray confirm ignored", mode_o, 1);
    req(3, 8);  ans(1); chk("R5 conf confirmed -> comm", mode_o, 2);
    req(1, 0);  chk("R7 unsub in comm dropped", pending_o, 0);
    req(6, 0);  req(7, 0);
    req(4, 3);  ans(1); chk("R8 bcast keeps comm", mode_o, 2);
    req(5, 0);  ans(1); chk("R6 endconf confirmed -> active", mode_o, 1);
    req(3, 2);  ans(1); chk("R5 second conf", mode_o, 2);

    // R6: end event with a confirm in the same cycle
    req(2, 0);
    @(negedge clk); cnf_valid_i = 1; cnf_ok_i = 1; end_conf_i = 1;
    @(negedge clk); idle_in();
    chk("R6 end event -> active", mode_o, 1);

    // R10: new request in the same cycle as the answer
    req(2, 4);
    d0 = drop_cnt_o;
    @(negedge clk); cnf_valid_i = 1; cnf_ok_i = 1; req_valid_i = 1; req_type_i = 4; req_arg_i = 1;
    @(negedge clk); idle_in();
    chk("R10 same-cycle request dropped", drop_cnt_o, d0 + 1);
    chk("R10 same-cycle no forward", fwd_valid_o, 0);
    req(1, 0); ans(1); chk("R4 unsub -> idle", mode_o, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      req_valid_i = ($urandom % 3) == 0;
      req_type_i  = 3'($urandom);
      req_arg_i   = ARG_W'($urandom);
      cnf_valid_i = ($urandom % 3) == 0;
      cnf_ok_i    = ($urandom % 4) != 0;
      end_conf_i  = ($urandom % 10) == 0;
    end
    @(negedge clk); idle_in();

    // R12 saturation
    do_reset(0);
    @(negedge clk); req_valid_i = 1; req_type_i = 2;
    repeat (CMAX + 20) @(negedge clk);
    idle_in(); @(negedge clk);
    chk("R12 drop saturates", drop_cnt_o, CMAX);

    // R2 base role
    do_reset(1);
    chk("R2 base mode", mode_o, 3);
    req(0, 0); req(2, 0);
    chk("R2 base forwards nothing", pending_o, 0);
    chk("R2 base drops", drop_cnt_o, 2);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule